// File: doc/BRIEF.md
# Daisy-Chained Serial Output Latch

This block drives a set of low-side output channels (four by default) from a serial word. The host presents one bit on a serial data pin and pulses a serial clock. Each rising edge pushes that bit into a holding shift register, and the oldest bit in that register leaves on a serial data output. The output can feed the data pin of the next device, so several devices can share one serial port. A rising edge on a separate latch pin copies the whole holding register into an output register. Until that edge, a word in transit through the shift register does not change the outputs.

Each channel output is on only when three things hold: its latched bit is 1, the active-low enable pin is low, and the per-channel block input from the protection logic is low. The enable and the block inputs only gate the outputs. Shifting goes on while the outputs are disabled, and a block does not change the stored data.

The serial clock, latch and data pins are asynchronous. Each passes through a two-flop synchroniser, and edges are detected in the system clock domain. An internal power-up reset clears the logic when no external reset is driven.

Top module: `serial_chan_latch`

## Requirements
- R1: Each detected rising edge of `ser_clk_in` shifts the holding register by one place toward the highest stage, and stage 0 takes the synchronised `ser_data_in`. Between edges the register holds its value. An edge takes effect within three `clk` cycles after the pin rises.
- R2: `ser_data_out` always equals the highest stage of the holding register. After each shift it therefore presents the bit that was shifted in CHANNELS clocks earlier.
- R3: A detected rising edge of `latch_in` copies every stage of the holding register into the output register in one step. Shifting without a latch edge leaves `chan_on` unchanged.
- R4: `chan_on[i]` is 1 exactly when latched bit i is 1, `enable_n` is 0 and `block_in[i]` is 0.
- R5: `enable_n` has no effect on shifting, on `ser_data_out` or on latching. Data loaded while the outputs are disabled appears once `enable_n` returns low.
- R6: A high `rst` clears both the holding register and the output register, so `chan_on` and `ser_data_out` become 0.
- R7: With `rst` never asserted, an internal power-up reset brings the block up with `chan_on` and `ser_data_out` at 0.
- R8: `block_in[i]` high forces `chan_on[i]` to 0 and leaves latched bit i unchanged. The channel returns to its latched value when the block is released.
- R9: If a serial clock edge and a latch edge are detected in the same `clk` cycle, the output register takes the holding register contents from before that shift.
- R10: Bit order: after CHANNELS serial clocks, the first bit sent sits in the highest stage and, once latched, controls `chan_on[CHANNELS-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, clears both stages |
| ser_clk_in | input | 1 | Asynchronous serial clock; a rising edge shifts |
| ser_data_in | input | 1 | Asynchronous serial data into stage 0 |
| latch_in | input | 1 | Asynchronous latch; a rising edge copies the holding register |
| enable_n | input | 1 | Active-low output enable |
| block_in | input | CHANNELS | Per-channel forced-off from protection logic |
| ser_data_out | output | 1 | Highest holding stage, for daisy chaining |
| chan_on | output | CHANNELS | Channel drive, 1 = on |

## Verification
The assertions assume that `ser_clk_in`, `latch_in` and `ser_data_in` stay at each level for at least three `clk` cycles. They also assume that data is stable from one cycle before a serial clock rise until after it has been sampled, so each pin level crosses the synchroniser without being lost. The stimulus changes pins only on falling `clk` edges and holds each level for at least four cycles. The one deliberate overlap is the R9 case, where the clock and latch pins rise together. The serial clock and latch pins are kept low while reset is active, so no false edge appears when reset is released.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int SCL_DEF_CHANNELS = 4;
    localparam int SCL_DEF_SYNC     = 2;
    localparam int SCL_DEF_POR      = 4;

    // Synchronised view of the serial pins, one clk domain
    typedef struct packed {
        logic sclk_rise;
        logic latch_rise;
        logic sdata;
    } scl_pins_t;

    function automatic logic gate_channel(input logic latched,
                                          input logic en_n,
                                          input logic blocked);
        return latched & ~en_n & ~blocked;
    endfunction

endpackage

// File: rtl/scl_por.sv
module scl_por #(
    parameter int HOLD = scl_pkg::SCL_DEF_POR
) (
    input  logic clk,
    input  logic rst,
    output logic rst_int
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt  = '0;
    logic          done = 1'b0;

    always_ff @(posedge clk) begin
        if (!done) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(HOLD - 1))
                done <= 1'b1;
        end
    end

    assign rst_int = rst | ~done;
endmodule

// File: rtl/scl_pin_sync.sv
module scl_pin_sync #(
    parameter int STAGES = scl_pkg::SCL_DEF_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/scl_shift_stage.sv
module scl_shift_stage #(
    parameter int CHANNELS = scl_pkg::SCL_DEF_CHANNELS
) (
    input  logic                clk,
    input  logic                rst,
    input  scl_pkg::scl_pins_t  pins,
    output logic [CHANNELS-1:0] hold_q,
    output logic                sout
);
    localparam int TOP = CHANNELS - 1;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (pins.sclk_rise)
            hold_q <= {hold_q[TOP-1:0], pins.sdata};
    end

    assign sout = hold_q[TOP];

    AST_SHIFT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        pins.sclk_rise |=> hold_q[TOP:1] == $past(hold_q[TOP-1:0])) // R1
        else $error("shift did not advance");
    AST_SHIFT_TAKES_DATA: assert property (@(posedge clk) disable iff (rst)
        pins.sclk_rise |=> hold_q[0] == $past(pins.sdata)) // R1
        else $error("stage 0 missed data");
    AST_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !pins.sclk_rise |=> $stable(hold_q)) // R1
        else $error("holding register moved without edge");
endmodule

// File: rtl/scl_latch_gate.sv
module scl_latch_gate #(
    parameter int CHANNELS = scl_pkg::SCL_DEF_CHANNELS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                latch_rise,
    input  logic [CHANNELS-1:0] hold_d,
    input  logic                enable_n,
    input  logic [CHANNELS-1:0] block_in,
    output logic [CHANNELS-1:0] chan_on
);
    logic [CHANNELS-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst)             lat_q <= '0;
        else if (latch_rise) lat_q <= hold_d;
    end

    generate
        for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
            assign chan_on[i] = scl_pkg::gate_channel(lat_q[i], enable_n, block_in[i]);
        end
    endgenerate

    AST_LATCH_COPIES: assert property (@(posedge clk) disable iff (rst)
        latch_rise |=> lat_q == $past(hold_d)) // R3
        else $error("latch did not copy holding register");
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !latch_rise |=> $stable(lat_q)) // R8
        else $error("latched data changed without latch edge");
endmodule

// File: rtl/serial_chan_latch.sv
module serial_chan_latch #(
    parameter int CHANNELS    = scl_pkg::SCL_DEF_CHANNELS,
    parameter int SYNC_STAGES = scl_pkg::SCL_DEF_SYNC,
    parameter int POR_CYCLES  = scl_pkg::SCL_DEF_POR
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_clk_in,
    input  logic                ser_data_in,
    input  logic                latch_in,
    input  logic                enable_n,
    input  logic [CHANNELS-1:0] block_in,
    output logic                ser_data_out,
    output logic [CHANNELS-1:0] chan_on
);
    logic               rst_i;
    scl_pkg::scl_pins_t pins;
    logic [CHANNELS-1:0] hold_q;
    logic               sclk_lvl, latch_lvl, data_rise;

    scl_por #(.HOLD(POR_CYCLES)) u_por (
        .clk(clk), .rst(rst), .rst_int(rst_i)
    );

    scl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst(rst_i), .pin(ser_clk_in),
        .level(sclk_lvl), .rise(pins.sclk_rise)
    );
    scl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_lat (
        .clk(clk), .rst(rst_i), .pin(latch_in),
        .level(latch_lvl), .rise(pins.latch_rise)
    );
    scl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst(rst_i), .pin(ser_data_in),
        .level(pins.sdata), .rise(data_rise)
    );

    scl_shift_stage #(.CHANNELS(CHANNELS)) u_shift (
        .clk(clk), .rst(rst_i), .pins(pins),
        .hold_q(hold_q), .sout(ser_data_out)
    );

    scl_latch_gate #(.CHANNELS(CHANNELS)) u_gate (
        .clk(clk), .rst(rst_i), .latch_rise(pins.latch_rise),
        .hold_d(hold_q), .enable_n(enable_n), .block_in(block_in),
        .chan_on(chan_on)
    );

    logic unused_lvls;
    assign unused_lvls = sclk_lvl ^ latch_lvl ^ data_rise;

    AST_DISABLED_ALL_OFF: assert property (@(posedge clk) disable iff (rst_i)
        enable_n |-> chan_on == '0) // R4
        else $error("channel on while disabled");
    AST_BLOCKED_OFF: assert property (@(posedge clk) disable iff (rst_i)
        (chan_on & block_in) == '0) // R8
        else $error("blocked channel on");
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (u_por.done == 1'b0)
        $past(rst) |-> (chan_on == '0) && !ser_data_out) // R6
        else $error("reset did not clear");
    AST_SOUT_SHIFTED: assert property (@(posedge clk) disable iff (rst_i)
        pins.sclk_rise |=> ser_data_out == $past(hold_q[CHANNELS-2])) // R2
        else $error("serial out not the shifted stage");
endmodule

// File: tb/sim_serial_chan_latch.sv
module sim_serial_chan_latch;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b0;
    logic ser_clk_in = 1'b0, ser_data_in = 1'b0, latch_in = 1'b0, enable_n = 1'b0;
    logic [N-1:0] block_in = '0;
    logic ser_data_out;
    logic [N-1:0] chan_on;

    int checks = 0, fails = 0;
    logic [N-1:0] m_sh = '0, m_lat = '0;

    always #2 clk = ~clk;

    serial_chan_latch u0 (
        .clk(clk), .rst(rst), .ser_clk_in(ser_clk_in), .ser_data_in(ser_data_in),
        .latch_in(latch_in), .enable_n(enable_n), .block_in(block_in),
        .ser_data_out(ser_data_out), .chan_on(chan_on)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input string req);
        ser_data_in = b;
        tick(1);
        ser_clk_in = 1'b1;
        tick(4);
        ser_clk_in = 1'b0;
        tick(4);
        m_sh = {m_sh[N-2:0], b};
        chk(req, 8'(ser_data_out), 8'(m_sh[N-1]));
    endtask

    task automatic send_word(input logic [N-1:0] w, input string req);
        for (int i = N - 1; i >= 0; i--) send_bit(w[i], req);
    endtask

    task automatic pulse_latch;
        latch_in = 1'b1;
        tick(4);
        latch_in = 1'b0;
        tick(4);
        m_lat = m_sh;
    endtask

    function automatic logic [N-1:0] expect_on();
        return enable_n ? '0 : (m_lat & ~block_in);
    endfunction

    initial begin
        tick(10);
        // R7: no external reset driven
        chk("R7 chan_on", 8'(chan_on), 8'h0);
        chk("R7 sout", 8'(ser_data_out), 8'h0);

        // R1 R2 R3 R4: every word pattern
        for (int w = 0; w < 16; w++) begin
            send_word(N'(w), "R2 sout");
            chk("R3 no change before latch", 8'(chan_on), 8'(expect_on()));
            pulse_latch();
            chk("R4 latched word", 8'(chan_on), 8'(w));
            chk("R1 holding word", 8'(m_sh), 8'(w));
        end

        // R10: first bit sent controls highest channel
        send_bit(1'b1, "R10 sout"); send_bit(1'b0, "R10 sout");
        send_bit(1'b0, "R10 sout"); send_bit(1'b0, "R10 sout");
        pulse_latch();
        chk("R10 first bit to top channel", 8'(chan_on), 8'h8);

        // R5: shifting and latching while disabled
        enable_n = 1'b1; tick(2);
        chk("R4 disabled off", 8'(chan_on), 8'h0);
        send_word(4'h5, "R5 sout while disabled");
        pulse_latch();
        chk("R5 still off", 8'(chan_on), 8'h0);
        enable_n = 1'b0; tick(2);
        chk("R5 data loaded while disabled", 8'(chan_on), 8'h5);

        // R8: all block patterns over a full word
        send_word(4'hF, "R2 sout");
        pulse_latch();
        for (int b = 0; b < 16; b++) begin
            block_in = N'(b); tick(2);
            chk("R8 blocked", 8'(chan_on), 8'(4'hF & ~b[3:0]));
        end
        block_in = '0; tick(2);
        chk("R8 data kept", 8'(chan_on), 8'hF);

        // R9: simultaneous edges latch pre-shift contents
        send_word(4'h6, "R2 sout");
        ser_data_in = 1'b1; tick(2);
        ser_clk_in = 1'b1; latch_in = 1'b1;
        tick(4);
        ser_clk_in = 1'b0; latch_in = 1'b0;
        tick(4);
        chk("R9 pre-shift latched", 8'(chan_on), 8'h6);
        m_lat = 4'h6; m_sh = 4'hD;
        chk("R9 shift still done", 8'(ser_data_out), 8'(m_sh[N-1]));
        pulse_latch();
        chk("R9 shifted word", 8'(chan_on), 8'hD);

        // R6: reset clears both stages
        rst = 1'b1; tick(2); rst = 1'b0; tick(2);
        m_sh = '0; m_lat = '0;
        chk("R6 chan_on", 8'(chan_on), 8'h0);
        chk("R6 sout", 8'(ser_data_out), 8'h0);
        pulse_latch();
        chk("R6 holding cleared", 8'(chan_on), 8'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule